// File: doc/BRIEF.md
# Counter Snapshot and Preload Buffer

This block keeps a 48-bit holding register between a byte-wide register bus and a free-running counter pair. The pair is a 15-bit prescaler that wraps at a programmable limit and a 32-bit main counter that advances once per prescaler wrap. One trigger event does one of two things. It can copy both live counts into the holding register in the same clock, so software reads a coherent value while the counters keep running. It can also move the holding register back into both counters at once.

Two configuration inputs control the block. The direction input selects capture (0) or preload (1). The source input selects the trigger: a rising edge on the sync pin (0) or an access on the register bus (1). With the bus as source, a read of any holding byte triggers a capture when the direction is capture, and a write to any holding byte triggers a preload when the direction is preload. The prescaler limit and the base address are parameters.

Top module: `shadow_xfer_ctrl`

## Requirements
- R1: While `rst` is high, both counters clear to zero on each clock edge. The holding register and `bus_rdata` also clear to zero.
- R2: With `tick_en` high and no preload, the prescaler increments on each clock. From a value at or above `DIV_MAX` it returns to 0, and at that edge the main counter increments by one. `div_wrap` is high combinationally in that cycle.
- R3: The holding register occupies bytes `BASE_ADDR`+0 to +5. Offset 0 is prescaler bits 7:0. Offset 1 is prescaler bits 14:8 in bits 6:0, and its bit 7 always reads 0. Offsets 2 to 5 are the main counter, least significant byte first. A read returns the addressed byte on `bus_rdata` after the clock edge that samples `bus_rd`.
- R4: With direction 0 and source 1, a read of a holding byte captures both counters at that edge. The returned byte already comes from the new capture.
- R5: After a capture the counters keep running, and the holding register stays unchanged until the next trigger or bus write.
- R6: With direction 0 and source 0, a rising edge of `sync_in` captures both counters at the edge where `sync_in` is first seen high. Holding `sync_in` high does not capture again, and bus reads do not capture.
- R7: With direction 1 and source 1, a write to a holding byte updates that byte at the write edge. Both counters are then preloaded from the updated holding register at the following edge.
- R8: With direction 1 and source 0, a rising edge of `sync_in` preloads both counters from the holding register at that edge.
- R9: A preload takes priority over a tick in the same cycle. The counters take exactly the holding value, and `div_wrap` stays low in that cycle.
- R10: A bus access that does not match the mode triggers nothing. A read in preload mode and a write in capture mode are both ignored as triggers, although the write still updates the holding byte. Bus accesses outside the six addresses have no effect, and reads of them return 0.
- R11: With source 1, edges on `sync_in` trigger nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counting enable for the prescaler |
| cfg_load_dir | input | 1 | 0 = capture counters, 1 = preload counters |
| cfg_bus_src | input | 1 | 0 = sync pin triggers, 1 = bus access triggers |
| sync_in | input | 1 | Trigger pin, rising edge active |
| bus_addr | input | 8 | Register bus byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| div_count | output | 15 | Prescaler count |
| main_count | output | 32 | Main counter |
| div_wrap | output | 1 | Prescaler wraps at the coming edge |

## Verification
The bench sweeps the prescaler through several wraps on a small limit, so a wrong wrap point or a missed carry into the main counter shows up at once. Captures are checked on every byte against the counts seen just before the triggering edge. A design that captured one cycle late, or that returned the old holding byte on the triggering read, would be off by one tick. Preloads are timed to the exact edge and applied while ticking. A design that let the tick win, or that loaded before the written byte landed, would leave a count one step high or a stale byte. Mode mismatches, a held-high sync pin and addresses just outside the window are each checked to leave the counters and the holding register untouched.

// File: rtl/shadow_xfer_pkg.sv
package shadow_xfer_pkg;

    localparam int DIV_W   = 15;
    localparam int MAIN_W  = 32;
    localparam int SNAP_W  = MAIN_W + 1 + DIV_W;
    localparam int NBYTES  = SNAP_W / 8;
    localparam int IDX_W   = $clog2(NBYTES);

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic              spare;
        logic [DIV_W-1:0]  div;
    } snap_t;

    typedef enum logic {
        XFER_CAPTURE = 1'b0,
        XFER_LOAD    = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        SRC_SYNC = 1'b0,
        SRC_BUS  = 1'b1
    } trig_src_e;

    function automatic logic [7:0] snap_byte(snap_t s, logic [IDX_W-1:0] idx);
        logic [SNAP_W-1:0] v;
        v         = s;
        v[DIV_W]  = 1'b0;
        return v[idx*8 +: 8];
    endfunction

    function automatic snap_t snap_put(snap_t s, logic [IDX_W-1:0] idx, logic [7:0] b);
        logic [SNAP_W-1:0] v;
        v            = s;
        v[idx*8 +: 8] = b;
        v[DIV_W]     = 1'b0;
        return snap_t'(v);
    endfunction

endpackage

// File: rtl/shadow_trig.sv
module shadow_trig
    import shadow_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xfer_dir_e dir,
    input  trig_src_e src,
    input  logic      sync_in,
    input  logic      bus_hit,
    input  logic      bus_rd,
    input  logic      bus_wr,
    output logic      cap_now,
    output logic      load_go
);

    logic sync_q;
    logic load_pend;
    logic sync_rise;

    assign sync_rise = sync_in && !sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 1'b0;
            load_pend <= 1'b0;
        end else begin
            sync_q    <= sync_in;
            load_pend <= (dir == XFER_LOAD) && (src == SRC_BUS) && bus_wr && bus_hit;
        end
    end

    always_comb begin
        cap_now = 1'b0;
        if (dir == XFER_CAPTURE) begin
            if (src == SRC_BUS) cap_now = bus_rd && bus_hit;
            else                cap_now = sync_rise;
        end
    end

    assign load_go = load_pend || ((dir == XFER_LOAD) && (src == SRC_SYNC) && sync_rise);

endmodule

// File: rtl/shadow_buf.sv
module shadow_buf
    import shadow_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_now,
    input  logic             bus_hit,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  snap_t            live,
    output snap_t            shadow,
    output logic [7:0]       rdata
);

    snap_t shadow_q;
    snap_t live_clean;

    always_comb begin
        live_clean       = live;
        live_clean.spare = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            rdata    <= '0;
        end else begin
            if (cap_now)                shadow_q <= live_clean;
            else if (bus_wr && bus_hit) shadow_q <= snap_put(shadow_q, idx, wdata);

            if (bus_rd) begin
                if (!bus_hit)     rdata <= '0;
                else if (cap_now) rdata <= snap_byte(live_clean, idx);
                else              rdata <= snap_byte(shadow_q, idx);
            end
        end
    end

    assign shadow = shadow_q;

endmodule

// File: rtl/cnt_pair.sv
module cnt_pair
    import shadow_xfer_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_MAX = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              load_go,
    input  snap_t             load_val,
    output logic [DIV_W-1:0]  div_q,
    output logic [MAIN_W-1:0] main_q,
    output logic              wrap
);

    localparam logic [DIV_W-1:0]  DIV_ONE  = 1;
    localparam logic [MAIN_W-1:0] MAIN_ONE = 1;

    assign wrap = tick_en && !load_go && (div_q >= DIV_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            main_q <= '0;
        end else if (load_go) begin
            div_q  <= load_val.div;
            main_q <= load_val.main;
        end else if (tick_en) begin
            if (wrap) begin
                div_q  <= '0;
                main_q <= main_q + MAIN_ONE;
            end else begin
                div_q  <= div_q + DIV_ONE;
            end
        end
    end

endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
    import shadow_xfer_pkg::*;
#(
    parameter logic [7:0]       BASE_ADDR = 8'h75,
    parameter logic [DIV_W-1:0] DIV_MAX   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              cfg_load_dir,
    input  logic              cfg_bus_src,
    input  logic              sync_in,
    input  logic [7:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [DIV_W-1:0]  div_count,
    output logic [MAIN_W-1:0] main_count,
    output logic              div_wrap
);

    localparam logic [7:0] NB8 = 8'(NBYTES);

    logic [7:0]       offs;
    logic             bus_hit;
    logic [IDX_W-1:0] idx;
    logic             cap_now;
    logic             load_go;
    snap_t            live;
    snap_t            shadow;

    assign offs    = bus_addr - BASE_ADDR;
    assign bus_hit = offs < NB8;
    assign idx     = offs[IDX_W-1:0];

    always_comb begin
        live.div   = div_count;
        live.spare = 1'b0;
        live.main  = main_count;
    end

    shadow_trig u_trig (
        .clk     (clk),
        .rst     (rst),
        .dir     (xfer_dir_e'(cfg_load_dir)),
        .src     (trig_src_e'(cfg_bus_src)),
        .sync_in (sync_in),
        .bus_hit (bus_hit),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .cap_now (cap_now),
        .load_go (load_go)
    );

    shadow_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .cap_now (cap_now),
        .bus_hit (bus_hit),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .idx     (idx),
        .wdata   (bus_wdata),
        .live    (live),
        .shadow  (shadow),
        .rdata   (bus_rdata)
    );

    cnt_pair #(.DIV_MAX(DIV_MAX)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load_go  (load_go),
        .load_val (shadow),
        .div_q    (div_count),
        .main_q   (main_count),
        .wrap     (div_wrap)
    );

endmodule

// File: rtl/shadow_xfer_chk.sv
module shadow_xfer_chk
    import shadow_xfer_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h75
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [7:0]        bus_addr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [DIV_W-1:0]  div_count,
    input logic [MAIN_W-1:0] main_count,
    input logic              div_wrap,
    input logic              load_go,
    input snap_t             shadow
);

    localparam logic [7:0]        HI_ADDR  = BASE_ADDR + 8'd1;
    localparam logic [MAIN_W-1:0] MAIN_ONE = 1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (div_count == '0) && (main_count == '0));

    // R2
    wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
        div_wrap |=> (div_count == '0) && (main_count == $past(main_count) + MAIN_ONE));

    // R9
    load_priority_chk: assert property (@(posedge clk) disable iff (rst)
        load_go |=> (div_count == $past(shadow.div)) && (main_count == $past(shadow.main)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load_go) |=> $stable(div_count) && $stable(main_count));

    // R3
    spare_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == HI_ADDR) |=> (bus_rdata[7] == 1'b0));

endmodule

bind shadow_xfer_ctrl shadow_xfer_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .div_count  (div_count),
    .main_count (main_count),
    .div_wrap   (div_wrap),
    .load_go    (load_go),
    .shadow     (shadow)
);

// File: tb/shadow_xfer_ctrl_bench.sv
module shadow_xfer_ctrl_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         DIVN       = 6;
    localparam logic [7:0] BASE       = 8'h75;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        cfg_load_dir = 1'b0;
    logic        cfg_bus_src = 1'b0;
    logic        sync_in = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [14:0] div_count;
    logic [31:0] main_count;
    logic        div_wrap;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_xfer_ctrl #(.BASE_ADDR(BASE), .DIV_MAX(15'(DIVN-1))) u_shadow_xfer_ctrl (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_load_dir(cfg_load_dir),
        .cfg_bus_src(cfg_bus_src), .sync_in(sync_in), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .div_count(div_count), .main_count(main_count), .div_wrap(div_wrap)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [14:0] d, input logic [31:0] m, input int k);
        logic [47:0] v;
        v = {m, 1'b0, d};
        return 8'((v >> (8*k)) & 48'hFF);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        cyc();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic counts_are(input string tag, input logic [14:0] d, input logic [31:0] m);
        check(div_count == d, tag, 64'(div_count), 64'(d));
        check(main_count == m, tag, 64'(main_count), 64'(m));
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rb;
        logic [14:0] sd;
        logic [31:0] sm;
        logic [7:0]  img [6];

        repeat (3) cyc();
        // R1 reset state
        counts_are("R1", 15'd0, 32'd0);
        check(bus_rdata == 8'h00, "R1 rdata", 64'(bus_rdata), 64'h0);
        rst = 1'b0;

        // R2 counting sweep across several prescaler wraps
        tick_en = 1'b1;
        for (int n = 0; n < 4*DIVN; n++) begin
            check(div_count == 15'(n % DIVN), "R2 div", 64'(div_count), 64'(n % DIVN));
            check(main_count == 32'(n / DIVN), "R2 main", 64'(main_count), 64'(n / DIVN));
            check(div_wrap == ((n % DIVN) == DIVN-1), "R2 wrap", 64'(div_wrap), 64'((n % DIVN) == DIVN-1));
            cyc();
        end
        tick_en = 1'b0;

        // R7 bus-triggered preload, one cycle after each write
        cfg_load_dir = 1'b1; cfg_bus_src = 1'b1;
        img[0] = 8'h03; img[1] = 8'h80; img[2] = 8'hD4;
        img[3] = 8'hC3; img[4] = 8'hB2; img[5] = 8'hA1;
        for (int k = 0; k < 6; k++) bus_write(BASE + 8'(k), img[k]);
        counts_are("R7 delay", 15'd3, 32'h00B2C3D4);
        cyc();
        counts_are("R7 load", 15'd3, 32'hA1B2C3D4);

        // R3 byte map, R10 reads in preload mode do not capture
        tick_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            bus_read(BASE + 8'(k), rb);
            check(rb == exp_byte(15'd3, 32'hA1B2C3D4, k), "R3 R10 map", 64'(rb),
                  64'(exp_byte(15'd3, 32'hA1B2C3D4, k)));
        end

        // R4 bus-read capture is coherent on the first byte
        cfg_load_dir = 1'b0;
        for (int r = 0; r < 12; r++) begin
            sd = div_count; sm = main_count;
            bus_read(BASE + 8'(r % 6), rb);
            check(rb == exp_byte(sd, sm, r % 6), "R4 capture", 64'(rb), 64'(exp_byte(sd, sm, r % 6)));
        end

        // R6 sync capture, R5 stable snapshot while counting
        cfg_bus_src = 1'b0;
        sync_in = 1'b1;
        sd = div_count; sm = main_count;
        cyc();
        repeat (10) cyc();
        sync_in = 1'b0;
        repeat (6) cyc();
        check(main_count != sm, "R5 running", 64'(main_count), 64'(sm));
        for (int k = 0; k < 6; k++) begin
            bus_read(BASE + 8'(k), rb);
            check(rb == exp_byte(sd, sm, k), "R5 R6 snapshot", 64'(rb), 64'(exp_byte(sd, sm, k)));
        end

        // R11 sync edge ignored while bus is the source
        cfg_bus_src = 1'b1;
        sync_in = 1'b1;
        cyc();
        sync_in = 1'b0;
        cyc();
        tick_en = 1'b0;
        cfg_load_dir = 1'b1;
        for (int k = 0; k < 6; k += 2) begin
            bus_read(BASE + 8'(k), rb);
            check(rb == exp_byte(sd, sm, k), "R11", 64'(rb), 64'(exp_byte(sd, sm, k)));
        end

        // R10 write in capture mode stores but does not preload
        cfg_load_dir = 1'b0;
        sd = div_count; sm = main_count;
        bus_write(BASE + 8'd2, 8'h55);
        cyc(); cyc();
        counts_are("R10 no load", sd, sm);
        cfg_load_dir = 1'b1;
        bus_read(BASE + 8'd2, rb);
        check(rb == 8'h55, "R10 stored", 64'(rb), 64'h55);

        // R10 addresses just outside the window
        bus_write(BASE - 8'd1, 8'h11);
        bus_write(BASE + 8'd6, 8'h22);
        cyc();
        counts_are("R10 outside", sd, sm);
        bus_read(BASE - 8'd1, rb);
        check(rb == 8'h00, "R10 outside rd", 64'(rb), 64'h0);
        bus_read(BASE + 8'd6, rb);
        check(rb == 8'h00, "R10 outside rd", 64'(rb), 64'h0);

        // R8 sync preload, R9 preload wins over tick
        cfg_bus_src = 1'b0;
        tick_en = 1'b1;
        img[0] = 8'h02; img[1] = 8'h00; img[2] = 8'h00;
        img[3] = 8'h01; img[4] = 8'h00; img[5] = 8'h00;
        for (int k = 0; k < 6; k++) bus_write(BASE + 8'(k), img[k]);
        sync_in = 1'b1;
        cyc();
        counts_are("R8 R9 sync load", 15'd2, 32'h100);
        sync_in = 1'b0;
        cyc();
        counts_are("R8 after", 15'd3, 32'h100);

        // R9 bus preload while ticking, then R2 wrap from the loaded value
        cfg_bus_src = 1'b1;
        bus_write(BASE, 8'h05);
        check(div_wrap == 1'b0, "R9 wrap held", 64'(div_wrap), 64'h0);
        cyc();
        counts_are("R9 bus load", 15'd5, 32'h100);
        cyc();
        counts_are("R2 post-load wrap", 15'd0, 32'h101);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule